// File: doc/BRIEF.md
# Periodic Output Update Timer

This block sits on a 16-bit register bus as a slave and paces the refresh of a front panel's lamps. It counts millisecond ticks and, once a programmed number of ticks has gone by, emits a one-clock update strobe, reloads itself and starts over. Each strobe also raises an update-event flag, which a read of the status register clears. When interrupts are enabled, that flag requests an interrupt. The interrupt vector is four above the one used by the input side, and the bus level is the same.

Two registers are selected by `reg_sel`. With `reg_sel` = 0 the status register is selected: bit 15 is the panel error flag, bit 7 the update event, bit 6 the interrupt enable, and bits 1:0 the test mode. With `reg_sel` = 1 the period register is selected, and bits 9:0 hold the period in milliseconds. The error flag only reports the `link_err` input. The timer and its interrupt keep running when no panel is connected, so the block also serves as a small general-purpose interval timer.

Top module: `out_update_timer`

## Requirements
- R1: After reset, the status register reads 0 apart from bit 15, which follows `link_err`. The period register reads 10, `test_mode` is 0, and `irq` and `upd_strobe` are low.
- R2: A write to the period register takes bits 9:0 and ignores bits 15:10. A value above 1000 is stored as 1000. The register reads back the stored value in bits 9:0, with zeros above.
- R3: With a period P of 1 or more, `upd_strobe` is high for exactly the one clock after the P-th tick since the last reload. The count then reloads from P.
- R4: A period of 0 stops the timer, so no strobe is produced however many ticks arrive.
- R5: The event flag (status bit 7) is set in the same cycle that `upd_strobe` is high.
- R6: A read of the status register (`rd_en` with `reg_sel` = 0) clears the event flag from the next cycle on.
- R7: A status read that coincides with a new expiry leaves the event flag set.
- R8: `irq` is high exactly while the event flag and the interrupt enable (status bit 6, writable) are both set.
- R9: Status bit 15 reflects `link_err`, and writes to bit 15 have no effect. The timer keeps producing strobes while `link_err` is high.
- R10: Status bits 1:0 are writable, read back, and drive `test_mode`: 0 normal, 1 lamp test, 2 full test, 3 powerless.
- R11: A write to the period register restarts the count from the new value, and a tick in the same cycle as the write is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 1 | Register select: 0 status, 1 period |
| wr_en | input | 1 | Write strobe for the selected register |
| rd_en | input | 1 | Read strobe; a status read clears the event flag |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data of the selected register, combinational |
| tick_ms | input | 1 | One-cycle pulse per millisecond |
| link_err | input | 1 | High when the panel is not reachable |
| upd_strobe | output | 1 | One-cycle lamp update pulse |
| test_mode | output | 2 | Panel test mode |
| irq | output | 1 | Output-side interrupt request |

## Verification
`rdata` is combinational and is due in the same cycle that `reg_sel` changes. `upd_strobe`, the event flag and `irq` change at the first clock edge after the expiring tick is sampled. The clear caused by a status read also takes effect at the edge that samples the read. The bench applies each stimulus for one clock edge, advances a behavioural model at that edge, and compares every output with the model at the following falling edge. The directed checks sample at those same falling edges.

// File: rtl/oupd_pkg.sv
`timescale 1ns/1ps
package oupd_pkg;
  localparam int DATA_W   = 16;
  localparam int ERR_BIT  = 15;
  localparam int EVT_BIT  = 7;
  localparam int IE_BIT   = 6;
  localparam int MODE_LSB = 0;
  localparam int MODE_W   = 2;

  typedef enum logic [MODE_W-1:0] {
    MODE_NORMAL = 2'd0,
    MODE_LAMP   = 2'd1,
    MODE_FULL   = 2'd2,
    MODE_DARK   = 2'd3
  } tmode_e;

  typedef enum logic {
    SEL_STAT   = 1'b0,
    SEL_PERIOD = 1'b1
  } rsel_e;
endpackage

// File: rtl/oupd_interval.sv
`timescale 1ns/1ps
module oupd_interval #(
  parameter int PER_W      = 10,
  parameter int MAX_PERIOD = 1000,
  parameter int RST_PERIOD = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             load,
  input  logic [PER_W-1:0] wr_val,
  output logic [PER_W-1:0] period,
  output logic             expire,
  output logic             strobe
);
  localparam logic [PER_W-1:0] MAX_V  = PER_W'(MAX_PERIOD);
  localparam logic [PER_W-1:0] RST_V  = PER_W'(RST_PERIOD);
  localparam logic [PER_W-1:0] ONE_V  = PER_W'(1);
  localparam logic [PER_W-1:0] ZERO_V = '0;

  logic [PER_W-1:0] per_q, per_d, cnt_q, cnt_d, wr_sat;
  logic             stb_q, stb_d, cnt_en, per_en;

  assign wr_sat = (wr_val > MAX_V) ? MAX_V : wr_val;
  assign expire = tick & ~load & (cnt_q == ONE_V);
  assign per_en = load;
  assign cnt_en = load | (tick & (cnt_q != ZERO_V));

  always_comb begin
    per_d = per_q;
    cnt_d = cnt_q;
    stb_d = expire;
    if (load) begin
      per_d = wr_sat;
      cnt_d = wr_sat;
    end else if (cnt_q == ONE_V) begin
      cnt_d = per_q;
    end else begin
      cnt_d = cnt_q - ONE_V;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q <= RST_V;
      cnt_q <= RST_V;
      stb_q <= 1'b0;
    end else begin
      if (per_en) per_q <= per_d;
      if (cnt_en) cnt_q <= cnt_d;
      stb_q <= stb_d;
    end
  end

  assign period = per_q;
  assign strobe = stb_q;

  assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= per_q);
  assert_period_cap_R2: assert property (@(posedge clk) disable iff (!rst_n)
    per_q <= MAX_V);
  assert_off_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q == ZERO_V && !load) |=> !stb_q);
endmodule

// File: rtl/oupd_regs.sv
`timescale 1ns/1ps
module oupd_regs
  import oupd_pkg::*;
#(
  parameter int PER_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sel,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] wdata,
  input  logic              link_err,
  input  logic              expire,
  input  logic [PER_W-1:0]  period,
  output logic              load,
  output logic [PER_W-1:0]  wr_val,
  output logic              evt,
  output logic              ie,
  output logic [MODE_W-1:0] mode,
  output logic [DATA_W-1:0] rdata
);
  logic              stat_wr, rd_clr;
  logic              evt_q, evt_d, ie_q, ie_d;
  logic [MODE_W-1:0] mode_q, mode_d;
  logic              unused_wbits;

  assign load         = wr & (sel == SEL_PERIOD);
  assign wr_val       = wdata[PER_W-1:0];
  assign stat_wr      = wr & (sel == SEL_STAT);
  assign rd_clr       = rd & (sel == SEL_STAT);
  assign unused_wbits = ^wdata[DATA_W-1:PER_W];

  always_comb begin
    evt_d  = expire | (evt_q & ~rd_clr);
    ie_d   = wdata[IE_BIT];
    mode_d = wdata[MODE_LSB +: MODE_W];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      evt_q  <= 1'b0;
      ie_q   <= 1'b0;
      mode_q <= MODE_NORMAL;
    end else begin
      evt_q <= evt_d;
      if (stat_wr) begin
        ie_q   <= ie_d;
        mode_q <= mode_d;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (sel == SEL_STAT) begin
      rdata[ERR_BIT]              = link_err;
      rdata[EVT_BIT]              = evt_q;
      rdata[IE_BIT]               = ie_q;
      rdata[MODE_LSB +: MODE_W]   = mode_q;
    end else begin
      rdata[PER_W-1:0] = period;
    end
  end

  assign evt  = evt_q;
  assign ie   = ie_q;
  assign mode = mode_q;

  assert_rd_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_clr && !expire) |=> !evt_q);
  assert_expire_sets_R7: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> evt_q);
endmodule

// File: rtl/out_update_timer.sv
`timescale 1ns/1ps
module out_update_timer
  import oupd_pkg::*;
#(
  parameter int PER_W      = 10,
  parameter int MAX_PERIOD = 1000,
  parameter int RST_PERIOD = 10
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_sel,
  input  logic        wr_en,
  input  logic        rd_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        tick_ms,
  input  logic        link_err,
  output logic        upd_strobe,
  output logic [1:0]  test_mode,
  output logic        irq
);
  logic             load, expire, evt, ie, strobe;
  logic [PER_W-1:0] wr_val, period;

  oupd_regs #(.PER_W(PER_W)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .sel      (reg_sel),
    .wr       (wr_en),
    .rd       (rd_en),
    .wdata    (wdata),
    .link_err (link_err),
    .expire   (expire),
    .period   (period),
    .load     (load),
    .wr_val   (wr_val),
    .evt      (evt),
    .ie       (ie),
    .mode     (test_mode),
    .rdata    (rdata)
  );

  oupd_interval #(
    .PER_W      (PER_W),
    .MAX_PERIOD (MAX_PERIOD),
    .RST_PERIOD (RST_PERIOD)
  ) u_interval (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (tick_ms),
    .load   (load),
    .wr_val (wr_val),
    .period (period),
    .expire (expire),
    .strobe (strobe)
  );

  assign upd_strobe = strobe;
  assign irq        = evt & ie;

  assert_strobe_flags_R5: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> evt);
  assert_irq_needs_evt_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!evt) |-> !irq);
endmodule

// File: tb/sim_out_update_timer.sv
`timescale 1ns/1ps
module sim_out_update_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, tick_ms = 1'b0, link_err = 1'b0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        upd_strobe, irq;
  logic [1:0]  test_mode;

  int n_chk = 0, n_bad = 0, n_stb = 0, s = 0;
  int m_per, m_cnt, m_mode;
  bit m_stb, m_evt, m_ie;

  always #2 clk = ~clk;

  out_update_timer u0 (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .tick_ms(tick_ms), .link_err(link_err),
    .upd_strobe(upd_strobe), .test_mode(test_mode), .irq(irq)
  );

  // behavioural reference, advanced at each rising edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_per = 10; m_cnt = 10; m_stb = 0; m_evt = 0; m_ie = 0; m_mode = 0;
    end else begin
      bit ld, ex, clr;
      ld  = wr_en && reg_sel;
      clr = rd_en && !reg_sel;
      ex  = tick_ms && !ld && (m_cnt == 1);
      if (ld) begin
        m_per = (int'(wdata[9:0]) > 1000) ? 1000 : int'(wdata[9:0]);
        m_cnt = m_per;
      end else if (tick_ms && m_cnt != 0) begin
        m_cnt = (m_cnt == 1) ? m_per : m_cnt - 1;
      end
      m_stb = ex;
      m_evt = ex || (m_evt && !clr);
      if (wr_en && !reg_sel) begin
        m_ie   = wdata[6];
        m_mode = int'(wdata[1:0]);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic compare();
    logic [15:0] exp;
    if (!reg_sel) exp = {link_err, 7'b0, m_evt, m_ie, 4'b0, m_mode[1:0]};
    else          exp = 16'(m_per);
    check(upd_strobe == m_stb, "R3 strobe", int'(upd_strobe), int'(m_stb));
    check(irq == (m_evt && m_ie), "R8 irq", int'(irq), int'(m_evt && m_ie));
    check(int'(test_mode) == m_mode, "R10 test_mode", int'(test_mode), m_mode);
    check(rdata == exp, reg_sel ? "R2 period read" : "R5 status read", int'(rdata), int'(exp));
  endtask

  task automatic cyc(input logic sl, input logic w, input logic r, input logic [15:0] d, input logic t);
    reg_sel = sl; wr_en = w; rd_en = r; wdata = d; tick_ms = t;
    @(posedge clk);
    @(negedge clk);
    compare();
    if (upd_strobe) n_stb++;
  endtask

  task automatic wr_reg(input logic sl, input logic [15:0] d);
    cyc(sl, 1'b1, 1'b0, d, 1'b0);
  endtask

  task automatic ticks(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      cyc(1'b0, 1'b0, 1'b0, 16'h0, 1'b1);
      for (int g = 0; g < gap; g++) cyc(1'b0, 1'b0, 1'b0, 16'h0, 1'b0);
    end
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("%0d/%0d checks passed", n_chk - n_bad + 1, n_chk + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    cyc(0, 0, 0, 0, 0);
    check(rdata == 16'h0000, "R1 status after reset", int'(rdata), 0);
    check(upd_strobe == 0 && irq == 0, "R1 outputs idle", int'({upd_strobe, irq}), 0);
    cyc(1, 0, 0, 0, 0);
    check(rdata == 16'd10, "R1 default period", int'(rdata), 10);
    check(test_mode == 2'd0, "R1 test mode", int'(test_mode), 0);

    // R3 default period of 10 ticks
    s = n_stb;
    ticks(9, 2);
    check(n_stb == s, "R3 no strobe before tenth tick", n_stb - s, 0);
    ticks(1, 2);
    check(n_stb == s + 1, "R3 strobe on tenth tick", n_stb - s, 1);
    ticks(10, 0);
    check(n_stb == s + 2, "R3 reload after strobe", n_stb - s, 2);

    // R5 R8 R6
    cyc(0, 1, 1, 16'h0000, 0);
    wr_reg(1, 16'd3);
    wr_reg(0, 16'h0040);
    ticks(3, 1);
    cyc(0, 0, 0, 0, 0);
    check(rdata[7] == 1'b1, "R5 event flag set", int'(rdata[7]), 1);
    check(irq == 1'b1, "R8 irq raised", int'(irq), 1);
    cyc(0, 0, 1, 0, 0);
    check(rdata[7] == 1'b0, "R6 flag cleared by read", int'(rdata[7]), 0);
    check(irq == 1'b0, "R6 irq dropped", int'(irq), 0);

    // R7 read coincides with expiry
    wr_reg(1, 16'd1);
    cyc(0, 0, 1, 0, 1);
    cyc(0, 0, 0, 0, 0);
    check(rdata[7] == 1'b1, "R7 flag kept on coincident read", int'(rdata[7]), 1);
    cyc(0, 0, 1, 0, 0);

    // R8 enable off
    wr_reg(0, 16'h0000);
    ticks(2, 0);
    check(irq == 1'b0, "R8 irq masked", int'(irq), 0);
    cyc(0, 0, 1, 0, 0);

    // R4 disabled
    wr_reg(1, 16'd0);
    s = n_stb;
    ticks(20, 0);
    check(n_stb == s, "R4 no strobe at period 0", n_stb - s, 0);

    // R2 saturation and field width
    wr_reg(1, 16'd1023);
    cyc(1, 0, 0, 0, 0);
    check(rdata == 16'd1000, "R2 saturate 1023", int'(rdata), 1000);
    wr_reg(1, 16'd999);
    cyc(1, 0, 0, 0, 0);
    check(rdata == 16'd999, "R2 keep 999", int'(rdata), 999);
    wr_reg(1, 16'hFC05);
    cyc(1, 0, 0, 0, 0);
    check(rdata == 16'd5, "R2 upper bits ignored", int'(rdata), 5);

    // R9 error flag and running without a panel
    link_err = 1'b1;
    wr_reg(1, 16'd2);
    cyc(0, 0, 0, 0, 0);
    check(rdata[15] == 1'b1, "R9 error flag shown", int'(rdata[15]), 1);
    s = n_stb;
    ticks(4, 1);
    check(n_stb == s + 2, "R9 timer runs with link_err", n_stb - s, 2);
    link_err = 1'b0;
    wr_reg(0, 16'h8000);
    cyc(0, 0, 1, 0, 0);
    check(rdata[15] == 1'b0, "R9 write to error flag ignored", int'(rdata[15]), 0);

    // R10 test modes
    for (int m = 0; m < 4; m++) begin
      wr_reg(0, 16'(m));
      cyc(0, 0, 0, 0, 0);
      check(int'(test_mode) == m, "R10 mode drive", int'(test_mode), m);
      check(int'(rdata[1:0]) == m, "R10 mode readback", int'(rdata[1:0]), m);
    end

    // R11 restart on period write, coincident tick ignored
    wr_reg(1, 16'd5);
    ticks(3, 0);
    cyc(1, 1, 0, 16'd5, 1);
    s = n_stb;
    ticks(4, 1);
    check(n_stb == s, "R11 restarted count not done", n_stb - s, 0);
    ticks(1, 1);
    check(n_stb == s + 1, "R11 strobe after full period", n_stb - s, 1);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule